// File: doc/BRIEF.md
# Banked Test Register Gateway

This block sits behind a management register file with 5-bit register addresses and 16-bit data. Three visible registers give access to a hidden set of banked internal registers: a test control register (address 20), a latched read-result register (address 21) and a staged write-data register (address 23). The hidden registers are held in small internal arrays: one array of 32 words for each of the banks 0, 1 and 3. Bank 2 has no storage.

Management software first opens the hidden banks with a fixed sequence of control writes. It then issues one read or one write through a single control word. When it is done it writes zero to the control register, which locks the banks again. For a write, the data goes into register 23 before the control word is written. For a read, the result is latched into register 21 on the clock edge that takes the control word.

Top module: `test_bank_gateway`

## Requirements
- R1: After reset, registers 20, 21 and 23 read 0, the banks are locked and every hidden word is 0.
- R2: A management read of address 20 or 23 returns the value last written there. Address 21 returns the latched read result. Every other address reads 0.
- R3: The banks open only after four consecutive control writes with the values 0x0000, 0x0400, 0x0000, 0x0400. Bit 10 is the test-mode bit.
- R4: While the banks are open, a control word with bit 15 set, bit 14 clear and bit 10 set reads the hidden word selected by bank bits 12:11 and read address bits 9:5. The result appears in register 21 from the clock edge that takes the control word onward. The write-address field does not affect a read.
- R5: While the banks are open, a control word with bit 14 set, bit 15 clear and bit 10 set stores the value of register 23 in the hidden word selected by bits 12:11 and write address bits 4:0. The read-address field does not affect a write.
- R6: A control write of 0x0000 locks the banks. A later command has no access until the full opening sequence is repeated.
- R7: Any control word that breaks the opening sequence returns the tracker to its start. A nonzero word without the test-mode bit also relocks open banks. A command while locked changes no hidden word, and if it has bit 15 set it clears register 21 to 0.
- R8: A control word with both bits 15 and 14 set performs no access and leaves register 21 unchanged.
- R9: Register 21 holds its value until the next control write that carries bit 15.
- R10: A read of bank 2 returns 0 and a write to bank 2 is discarded. The banks are independent, so the same address in another bank is not affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_we | input | 1 | Management write strobe, one cycle per write |
| mgmt_addr | input | 5 | Management write register address |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_raddr | input | 5 | Management read register address |
| mgmt_rdata | output | 16 | Read data for mgmt_raddr (combinational) |

## Verification
The bank access is tried with the following control words:
- Reads and writes to banks 3, 1, 0 and 2 with distinct data. These show that the bank field is decoded and that the banks are kept apart.
- A write whose unused read-address field points elsewhere. This shows that the two address fields are separate.
- Words with both command bits set, and words without the test-mode bit. Each would corrupt a known word or return stale data if it were taken as a command.
- A full opening, a relock, a locked write and a sequence broken by a repeated test-mode word. These show that access depends on the exact four-write order.

All hidden state is observed only through register 21, read back after each command.

// File: rtl/tbg_pkg.sv
package tbg_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int BANK_W = 2;
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int REGS_PER_BANK = 1 << ADDR_W;
  localparam int UNUSED_BANK = 2;

  localparam logic [ADDR_W-1:0] CTL_ADDR  = 5'd20;
  localparam logic [ADDR_W-1:0] RDAT_ADDR = 5'd21;
  localparam logic [ADDR_W-1:0] WDAT_ADDR = 5'd23;

  localparam logic [DATA_W-1:0] TM_ONLY = 16'h0400;

  typedef enum logic [2:0] {
    LK_IDLE, LK_Z1, LK_T1, LK_Z2, LK_OPEN
  } lock_state_e;

  typedef struct packed {
    logic              rd;
    logic              wr;
    logic              rsv;
    logic [BANK_W-1:0] bank;
    logic              tm;
    logic [ADDR_W-1:0] raddr;
    logic [ADDR_W-1:0] waddr;
  } ctl_word_t;

  // Next state of the opening-sequence tracker for one control write
  function automatic lock_state_e lock_next(lock_state_e cur, logic [DATA_W-1:0] w);
    ctl_word_t c;
    c = ctl_word_t'(w);
    if (w == '0)
      return (cur == LK_T1) ? LK_Z2 : LK_Z1;
    else if (w == TM_ONLY) begin
      case (cur)
        LK_Z1:   return LK_T1;
        LK_Z2:   return LK_OPEN;
        LK_OPEN: return LK_OPEN;
        default: return LK_IDLE;
      endcase
    end else if (cur == LK_OPEN && c.tm)
      return LK_OPEN;
    else
      return LK_IDLE;
  endfunction
endpackage

// File: rtl/tbg_lock_fsm.sv
module tbg_lock_fsm
  import tbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_word,
  output logic              open_q
);
  lock_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      state_q <= LK_IDLE;
    else if (ctl_wr) state_q <= lock_next(state_q, ctl_word);
  end

  assign open_q = (state_q == LK_OPEN);

  // R3
  open_needs_tm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && !$past(open_q)) |-> ($past(ctl_wr) && $past(ctl_word) == TM_ONLY));

  // R6
  zero_relocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_word == '0) |=> !open_q);
endmodule

// File: rtl/tbg_bank_store.sv
module tbg_bank_store
  import tbg_pkg::*;
#(
  parameter int NBANK  = NUM_BANKS,
  parameter int NREG   = REGS_PER_BANK,
  parameter int DW     = DATA_W,
  parameter int UNUSED = UNUSED_BANK,
  localparam int BW    = $clog2(NBANK),
  localparam int AW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [BW-1:0] wbank,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [BW-1:0] rbank,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [NBANK-1:0][DW-1:0] bank_rd;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    if (b == UNUSED) begin : g_empty
      assign bank_rd[b] = '0;
    end else begin : g_mem
      logic [DW-1:0] regs_q [NREG];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (we && wbank == BW'(b)) begin
          regs_q[waddr] <= wdata;
        end
      end
      assign bank_rd[b] = regs_q[raddr];
    end
  end

  assign rdata = bank_rd[rbank];
endmodule

// File: rtl/test_bank_gateway.sv
module test_bank_gateway
  import tbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mgmt_we,
  input  logic [ADDR_W-1:0] mgmt_addr,
  input  logic [DATA_W-1:0] mgmt_wdata,
  input  logic [ADDR_W-1:0] mgmt_raddr,
  output logic [DATA_W-1:0] mgmt_rdata
);
  ctl_word_t         cw;
  logic              ctl_wr, stage_wr, open_q;
  logic              access_ok, rd_go, wr_go, rd_kill, cmd_conflict;
  logic [DATA_W-1:0] ctl_q, stage_q, rd_latch_q, store_rdata;

  assign cw           = ctl_word_t'(mgmt_wdata);
  assign ctl_wr       = mgmt_we && (mgmt_addr == CTL_ADDR);
  assign stage_wr     = mgmt_we && (mgmt_addr == WDAT_ADDR);
  assign access_ok    = ctl_wr && open_q && cw.tm;
  assign cmd_conflict = ctl_wr && cw.rd && cw.wr;
  assign rd_go        = access_ok && cw.rd && !cw.wr;
  assign wr_go        = access_ok && cw.wr && !cw.rd;
  assign rd_kill      = ctl_wr && cw.rd && !cw.wr && !(open_q && cw.tm);

  tbg_lock_fsm u_lock (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
    .ctl_word(mgmt_wdata), .open_q(open_q)
  );

  tbg_bank_store u_store (
    .clk(clk), .rst_n(rst_n),
    .we(wr_go), .wbank(cw.bank), .waddr(cw.waddr), .wdata(stage_q),
    .rbank(cw.bank), .raddr(cw.raddr), .rdata(store_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      stage_q    <= '0;
      rd_latch_q <= '0;
    end else begin
      if (ctl_wr)   ctl_q   <= mgmt_wdata;
      if (stage_wr) stage_q <= mgmt_wdata;
      if (rd_go)        rd_latch_q <= store_rdata;
      else if (rd_kill) rd_latch_q <= '0;
    end
  end

  always_comb begin
    case (mgmt_raddr)
      CTL_ADDR:  mgmt_rdata = ctl_q;
      RDAT_ADDR: mgmt_rdata = rd_latch_q;
      WDAT_ADDR: mgmt_rdata = stage_q;
      default:   mgmt_rdata = '0;
    endcase
  end

  // R8
  conflict_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_conflict |=> $stable(rd_latch_q));

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_wr && mgmt_wdata[15]) |=> $stable(rd_latch_q));

  // R7
  locked_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !open_q && cw.rd && !cw.wr) |=> (rd_latch_q == '0));

  // R10
  unused_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && cw.bank == BANK_W'(UNUSED_BANK)) |=> (rd_latch_q == '0));
endmodule

// File: tb/test_bank_gateway_bench.sv
module test_bank_gateway_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mgmt_we = 1'b0;
  logic [4:0]  mgmt_addr = '0;
  logic [15:0] mgmt_wdata = '0;
  logic [4:0]  mgmt_raddr = '0;
  logic [15:0] mgmt_rdata;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  test_bank_gateway u_test_bank_gateway (
    .clk(clk), .rst_n(rst_n), .mgmt_we(mgmt_we), .mgmt_addr(mgmt_addr),
    .mgmt_wdata(mgmt_wdata), .mgmt_raddr(mgmt_raddr), .mgmt_rdata(mgmt_rdata)
  );

  // entry: {op (0 write, 1 check), addr, data, requirement number}
  localparam int NV = 63;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0,5'd20,16'h0000,4'd3}, {1'b0,5'd20,16'h0400,4'd3},   // R3 opening
    {1'b0,5'd20,16'h0000,4'd3}, {1'b0,5'd20,16'h0400,4'd3},
    {1'b0,5'd23,16'h1234,4'd5}, {1'b0,5'd20,16'h5C1B,4'd5},   // R5 bank3[27]
    {1'b0,5'd20,16'h9F60,4'd4}, {1'b1,5'd21,16'h1234,4'd4},   // R4
    {1'b1,5'd23,16'h1234,4'd2}, {1'b1,5'd20,16'h9F60,4'd2},   // R2
    {1'b0,5'd23,16'hBEEF,4'd5}, {1'b0,5'd20,16'h4C0C,4'd5},   // R5 bank1[12]
    {1'b0,5'd20,16'h8D80,4'd5}, {1'b1,5'd21,16'hBEEF,4'd5},
    {1'b0,5'd20,16'h9D80,4'd10},{1'b1,5'd21,16'h0000,4'd10},  // R10 bank3[12]
    {1'b0,5'd23,16'h5555,4'd10},{1'b0,5'd20,16'h540C,4'd10},  // R10 bank2
    {1'b0,5'd20,16'h9580,4'd10},{1'b1,5'd21,16'h0000,4'd10},
    {1'b0,5'd23,16'h7777,4'd8}, {1'b0,5'd20,16'hDF7B,4'd8},   // R8 both bits
    {1'b1,5'd21,16'h0000,4'd8}, {1'b0,5'd20,16'h9F60,4'd8},
    {1'b1,5'd21,16'h1234,4'd8},
    {1'b0,5'd23,16'h0A0A,4'd4}, {1'b0,5'd20,16'h44A3,4'd4},   // R4 split fields
    {1'b0,5'd20,16'h8460,4'd4}, {1'b1,5'd21,16'h0A0A,4'd4},
    {1'b0,5'd20,16'h84A0,4'd4}, {1'b1,5'd21,16'h0000,4'd4},
    {1'b0,5'd20,16'h9F60,4'd9}, {1'b1,5'd21,16'h1234,4'd9},   // R9 hold
    {1'b0,5'd23,16'h4321,4'd9}, {1'b1,5'd21,16'h1234,4'd9},
    {1'b0,5'd20,16'h9B60,4'd7}, {1'b1,5'd21,16'h0000,4'd7},   // R7 no test mode
    {1'b0,5'd20,16'h9F60,4'd7}, {1'b1,5'd21,16'h0000,4'd7},
    {1'b0,5'd20,16'h0000,4'd3}, {1'b0,5'd20,16'h0400,4'd3},
    {1'b0,5'd20,16'h0000,4'd3}, {1'b0,5'd20,16'h0400,4'd3},
    {1'b0,5'd20,16'h9F60,4'd3}, {1'b1,5'd21,16'h1234,4'd3},
    {1'b0,5'd20,16'h0000,4'd6}, {1'b0,5'd20,16'h9F60,4'd6},   // R6 relock
    {1'b1,5'd21,16'h0000,4'd6},
    {1'b0,5'd23,16'hFFFF,4'd7}, {1'b0,5'd20,16'h5C1B,4'd7},   // R7 locked write
    {1'b0,5'd20,16'h0000,4'd3}, {1'b0,5'd20,16'h0400,4'd3},
    {1'b0,5'd20,16'h0000,4'd3}, {1'b0,5'd20,16'h0400,4'd3},
    {1'b0,5'd20,16'h9F60,4'd7}, {1'b1,5'd21,16'h1234,4'd7},
    {1'b0,5'd20,16'h0000,4'd7}, {1'b0,5'd20,16'h0400,4'd7},   // R7 broken order
    {1'b0,5'd20,16'h0400,4'd7}, {1'b0,5'd20,16'h0000,4'd7},
    {1'b0,5'd20,16'h0400,4'd7}, {1'b0,5'd20,16'h9F60,4'd7},
    {1'b1,5'd21,16'h0000,4'd7}
  };

  task automatic mwrite(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    mgmt_we = 1'b1; mgmt_addr = a; mgmt_wdata = d;
    @(negedge clk);
    mgmt_we = 1'b0;
  endtask

  task automatic mcheck(input logic [4:0] a, input logic [15:0] exp, input int req);
    @(negedge clk);
    mgmt_raddr = a;
    #1;
    n_checks++;
    if (mgmt_rdata !== exp) begin
      n_fail++;
      $display("FAIL R%0d addr %0d: actual %h expected %h", req, a, mgmt_rdata, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    mcheck(5'd20, 16'h0000, 1);
    mcheck(5'd21, 16'h0000, 1);
    mcheck(5'd23, 16'h0000, 1);
    // R2 other addresses
    mcheck(5'd22, 16'h0000, 2);
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][25]) mcheck(VEC[i][24:20], VEC[i][19:4], int'(VEC[i][3:0]));
      else            mwrite(VEC[i][24:20], VEC[i][19:4]);
    end
    mwrite(5'd20, 16'h0400);
    mcheck(5'd0, 16'h0000, 2);  // R2 unmapped address
    // R1 reset mid-run clears hidden words
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    mcheck(5'd23, 16'h0000, 1);
    mwrite(5'd20, 16'h0000); mwrite(5'd20, 16'h0400);
    mwrite(5'd20, 16'h0000); mwrite(5'd20, 16'h0400);
    mwrite(5'd20, 16'h8D80);
    mcheck(5'd21, 16'h0000, 1);
    mwrite(5'd20, 16'h0000);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule